// File: doc/BRIEF.md
# Configurable-Precision SIMD Multiply-Accumulate Unit

This block is a pipelined vector multiply-accumulate datapath. Each valid cycle it takes two wide operand vectors and multiplies them element by element at one of several integer precisions. It sums consecutive groups of products into accumulator lanes and folds those sums into a signed accumulator register. The register is either overwritten with the new sums or has them added to it. The accumulator is 32·SLICES bits wide. Depending on the precision mode, it is treated either as SLICES lanes of 32 bits or as SLICES/2 lanes of 64 bits.

The number of products that feed one lane equals the mode's multiply count divided by its lane count. At the full size (SLICES = 32) the multiply counts per cycle are:

| Mode | Multiplies per cycle |
|------|----------------------|
| int8×int8 | 256 |
| int8×int4 | 512 |
| int16×int8 | 128 |
| int16×int16 | 64 |

The default SLICES of 4 scales every count down by eight. The signedness of each operand is chosen separately, and the accumulator is always signed.

A result appears a fixed three cycles after its inputs. Consecutive operations can issue on back-to-back cycles, and each one sees the accumulator as left by the previous one.

Top module: `vec_mac_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid is 0 and acc_vec is all zeros.
- R2: An operation sampled with in_valid high at a rising edge updates acc_vec at the second rising edge after it, and out_valid is high in the cycle that follows that edge. out_valid is low in every other cycle, so out_valid equals in_valid as sampled three edges earlier.
- R3: acc_vec does not change in any cycle after which out_valid is low. In particular, inputs presented with in_valid low (including load_acc and nonzero operands) leave it unchanged.
- R4: prec_mode selects the element widths, the products per lane and the lane width as follows:

  | prec_mode | A element | B element | Products per lane | Lanes |
  |-----------|-----------|-----------|-------------------|-------|
  | 0 | 8-bit | 8-bit | 8 | 32-bit |
  | 1 | 8-bit | 4-bit | 16 | 32-bit |
  | 2 | 16-bit | 16-bit | 2 | 32-bit |
  | 3 | 16-bit | 16-bit | 4 | 64-bit |
  | 4 | 16-bit | 8-bit | 4 | 32-bit |
  | 5 | 16-bit | 8-bit | 8 | 64-bit |

- R5: Element i of opa_vec occupies bits [i·wa +: wa] and element i of opb_vec occupies bits [i·wb +: wb]. Lane j sums the products of elements j·G through j·G+G−1, where G is the number of products per lane. A 32-bit lane j is acc_vec[32j +: 32] and a 64-bit lane j is acc_vec[64j +: 64].
- R6: opa_signed and opb_signed independently make the elements of opa_vec and opb_vec two's-complement (1) or unsigned (0).
- R7: With load_acc = 1 the lane's sum of products replaces the lane value.
- R8: With load_acc = 0 the sum is added to the lane value. The addition wraps modulo 2 to the power of the lane width, with no carry between lanes.
- R9: Both lane widths share one register. A 64-bit lane j reads and writes the bits of 32-bit lanes 2j (the low half) and 2j+1.
- R10: prec_mode values 6 and 7 behave exactly as value 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| opa_vec | input | 128·SLICES | First operand vector |
| opb_vec | input | 64·SLICES | Second operand vector |
| prec_mode | input | 3 | Precision and lane-width select (R4) |
| opa_signed | input | 1 | opa_vec elements are signed |
| opb_signed | input | 1 | opb_vec elements are signed |
| load_acc | input | 1 | 1: overwrite lanes, 0: accumulate |
| out_valid | output | 1 | acc_vec has just taken a new result |
| acc_vec | output | 32·SLICES | Accumulator register |

## Verification
The assertions take for granted that in_valid, load_acc and opa_vec are never unknown once reset is released, and that reset is released away from a rising edge. Under those conditions, a valid multiply by an all-zero opa_vec must leave the accumulator unchanged or cleared depending on load_acc, whatever the mode or signedness. The stimulus changes every input only at the falling clock edge and keeps in_valid low while reset is held. It uses the default SLICES of 4, which is even, so that every 64-bit lane has both halves.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    // precision mode codes (see R4, R10)
    localparam logic [2:0] PM_I8I8     = 3'd0;
    localparam logic [2:0] PM_I8I4     = 3'd1;
    localparam logic [2:0] PM_I16I16_N = 3'd2;
    localparam logic [2:0] PM_I16I16_W = 3'd3;
    localparam logic [2:0] PM_I16I8_N  = 3'd4;
    localparam logic [2:0] PM_I16I8_W  = 3'd5;

    // every element is widened to this many bits before multiplying
    localparam int EXT_W  = 17;
    localparam int PROD_W = 2 * EXT_W;
    // per-slice partial sum, wide enough for 16 int8*int4 or 4 u16*u16 terms
    localparam int SUM_W  = 40;
    // most products one 32-bit slice ever reduces
    localparam int MAX_TERMS = 16;

    // products feeding each 32-bit slice of the accumulator
    function automatic int terms_per_slice(input logic [2:0] m);
        case (m)
            PM_I8I4:                  return 16;
            PM_I16I16_N, PM_I16I16_W: return 2;
            PM_I16I8_N,  PM_I16I8_W:  return 4;
            default:                  return 8;
        endcase
    endfunction

    // modes whose lanes span two adjacent 32-bit slices
    function automatic logic wide_lanes(input logic [2:0] m);
        return (m == PM_I16I16_W) || (m == PM_I16I8_W);
    endfunction

endpackage

// File: rtl/vmac_mul_stage.sv
// Stage 1: per-slot operand select, sign handling and multiply.
module vmac_mul_stage
    import vmac_pkg::*;
#(
    parameter  int SLICES = 4,
    localparam int SLOTS  = 16 * SLICES,
    localparam int A_W    = 128 * SLICES,
    localparam int B_W    = 64 * SLICES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [2:0]                    mode,
    input  logic                          a_sgn,
    input  logic                          b_sgn,
    input  logic                          load,
    input  logic [A_W-1:0]                opa,
    input  logic [B_W-1:0]                opb,
    output logic                          o_vld,
    output logic [2:0]                    o_mode,
    output logic                          o_load,
    output logic [SLOTS-1:0][PROD_W-1:0]  o_prod
);

    typedef struct packed {
        logic                         vld;
        logic [2:0]                   mode;
        logic                         load;
        logic [SLOTS-1:0][PROD_W-1:0] prod;
    } mul_st_t;

    mul_st_t st_d, st_q;
    logic [SLOTS-1:0][PROD_W-1:0] prod_c;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [EXT_W-1:0] a8, a16, b4, b8, b16;
        logic [EXT_W-1:0] xa, xb;
        logic signed [PROD_W-1:0] xa_w, xb_w;

        // 8-bit A and 4-bit B fields exist for every slot
        assign a8 = {{(EXT_W-8){a_sgn & opa[s*8+7]}}, opa[s*8 +: 8]};
        assign b4 = {{(EXT_W-4){b_sgn & opb[s*4+3]}}, opb[s*4 +: 4]};

        if (s < 8 * SLICES) begin : g_mid
            assign a16 = {a_sgn & opa[s*16+15], opa[s*16 +: 16]};
            assign b8  = {{(EXT_W-8){b_sgn & opb[s*8+7]}}, opb[s*8 +: 8]};
        end else begin : g_mid_none
            assign a16 = '0;
            assign b8  = '0;
        end

        if (s < 4 * SLICES) begin : g_b16
            assign b16 = {b_sgn & opb[s*16+15], opb[s*16 +: 16]};
        end else begin : g_b16_none
            assign b16 = '0;
        end

        always_comb begin
            case (mode)
                PM_I8I4: begin
                    xa = a8;
                    xb = b4;
                end
                PM_I16I16_N, PM_I16I16_W: begin
                    xa = a16;
                    xb = b16;
                end
                PM_I16I8_N, PM_I16I8_W: begin
                    xa = a16;
                    xb = b8;
                end
                default: begin
                    xa = a8;
                    xb = b8;
                end
            endcase
        end

        assign xa_w = {{EXT_W{xa[EXT_W-1]}}, xa};
        assign xb_w = {{EXT_W{xb[EXT_W-1]}}, xb};
        assign prod_c[s] = xa_w * xb_w;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.mode = mode;
            st_d.load = load;
            st_d.prod = prod_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_vld  = st_q.vld;
    assign o_mode = st_q.mode;
    assign o_load = st_q.load;
    assign o_prod = st_q.prod;

endmodule

// File: rtl/vmac_sum_stage.sv
// Stage 2: post-adder, one partial sum per 32-bit slice.
module vmac_sum_stage
    import vmac_pkg::*;
#(
    parameter  int SLICES = 4,
    localparam int SLOTS  = 16 * SLICES,
    localparam int IDX_W  = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          i_vld,
    input  logic [2:0]                    i_mode,
    input  logic                          i_load,
    input  logic [SLOTS-1:0][PROD_W-1:0]  i_prod,
    output logic                          o_vld,
    output logic [2:0]                    o_mode,
    output logic                          o_load,
    output logic [SLICES-1:0][SUM_W-1:0]  o_sum
);

    typedef struct packed {
        logic                         vld;
        logic [2:0]                   mode;
        logic                         load;
        logic [SLICES-1:0][SUM_W-1:0] sum;
    } sum_st_t;

    sum_st_t st_d, st_q;

    always_comb begin
        int                       grp;
        logic [IDX_W-1:0]         idx;
        logic signed [SUM_W-1:0]  part;

        st_d     = st_q;
        st_d.vld = i_vld;
        grp      = terms_per_slice(i_mode);
        idx      = '0;
        part     = '0;
        if (i_vld) begin
            st_d.mode = i_mode;
            st_d.load = i_load;
            for (int j = 0; j < SLICES; j++) begin
                part = '0;
                for (int k = 0; k < MAX_TERMS; k++) begin
                    if (k < grp) begin
                        // consecutive slots feed one slice
                        idx  = IDX_W'(j * grp + k);
                        part = part + SUM_W'($signed(i_prod[idx]));
                    end
                end
                st_d.sum[j] = part;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_vld  = st_q.vld;
    assign o_mode = st_q.mode;
    assign o_load = st_q.load;
    assign o_sum  = st_q.sum;

endmodule

// File: rtl/vmac_acc_bank.sv
// Stage 3: accumulator register, 32-bit or paired 64-bit lanes.
module vmac_acc_bank
    import vmac_pkg::*;
#(
    parameter  int SLICES = 4,
    localparam int ACC_W  = 32 * SLICES,
    localparam int PAIRS  = SLICES / 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          i_vld,
    input  logic [2:0]                    i_mode,
    input  logic                          i_load,
    input  logic [SLICES-1:0][SUM_W-1:0]  i_sum,
    output logic                          o_vld,
    output logic [ACC_W-1:0]              o_acc
);

    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        logic [63:0] base64, add64;
        logic [31:0] base32;

        st_d     = st_q;
        st_d.vld = i_vld;
        base64   = '0;
        add64    = '0;
        base32   = '0;
        if (i_vld) begin
            if (wide_lanes(i_mode)) begin
                for (int p = 0; p < PAIRS; p++) begin
                    add64  = 64'($signed(i_sum[2*p])) + 64'($signed(i_sum[2*p+1]));
                    base64 = i_load ? 64'd0 : st_q.acc[p*64 +: 64];
                    st_d.acc[p*64 +: 64] = base64 + add64;
                end
            end else begin
                for (int j = 0; j < SLICES; j++) begin
                    base32 = i_load ? 32'd0 : st_q.acc[j*32 +: 32];
                    st_d.acc[j*32 +: 32] = base32 + i_sum[j][31:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_vld = st_q.vld;
    assign o_acc = st_q.acc;

endmodule

// File: rtl/vec_mac_unit.sv
module vec_mac_unit
    import vmac_pkg::*;
#(
    parameter  int SLICES = 4,
    localparam int SLOTS  = 16 * SLICES,
    localparam int A_W    = 128 * SLICES,
    localparam int B_W    = 64 * SLICES,
    localparam int ACC_W  = 32 * SLICES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [A_W-1:0]   opa_vec,
    input  logic [B_W-1:0]   opb_vec,
    input  logic [2:0]       prec_mode,
    input  logic             opa_signed,
    input  logic             opb_signed,
    input  logic             load_acc,
    output logic             out_valid,
    output logic [ACC_W-1:0] acc_vec
);

    logic                         m_vld, m_load;
    logic [2:0]                   m_mode;
    logic [SLOTS-1:0][PROD_W-1:0] m_prod;

    logic                         s_vld, s_load;
    logic [2:0]                   s_mode;
    logic [SLICES-1:0][SUM_W-1:0] s_sum;

    vmac_mul_stage #(.SLICES(SLICES)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mode     (prec_mode),
        .a_sgn    (opa_signed),
        .b_sgn    (opb_signed),
        .load     (load_acc),
        .opa      (opa_vec),
        .opb      (opb_vec),
        .o_vld    (m_vld),
        .o_mode   (m_mode),
        .o_load   (m_load),
        .o_prod   (m_prod)
    );

    vmac_sum_stage #(.SLICES(SLICES)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .i_vld  (m_vld),
        .i_mode (m_mode),
        .i_load (m_load),
        .i_prod (m_prod),
        .o_vld  (s_vld),
        .o_mode (s_mode),
        .o_load (s_load),
        .o_sum  (s_sum)
    );

    vmac_acc_bank #(.SLICES(SLICES)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .i_vld  (s_vld),
        .i_mode (s_mode),
        .i_load (s_load),
        .i_sum  (s_sum),
        .o_vld  (out_valid),
        .o_acc  (acc_vec)
    );

endmodule

// File: rtl/vec_mac_unit_chk.sv
module vec_mac_unit_chk #(
    parameter  int SLICES = 4,
    localparam int A_W    = 128 * SLICES,
    localparam int ACC_W  = 32 * SLICES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             load_acc,
    input logic [A_W-1:0]   opa_vec,
    input logic             out_valid,
    input logic [ACC_W-1:0] acc_vec
);

    // edges seen since reset release, saturating at the pipeline depth
    logic [1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd0) |-> (!out_valid && acc_vec == '0));  // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));  // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd0 && !out_valid) |-> (acc_vec == $past(acc_vec)));  // R3

    AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(in_valid, 3) && $past(load_acc, 3) && $past(opa_vec, 3) == '0)
        |-> (acc_vec == '0));  // R7

    AST_ZERO_ADD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && $past(in_valid, 3) && !$past(load_acc, 3) && $past(opa_vec, 3) == '0)
        |-> (acc_vec == $past(acc_vec)));  // R8

endmodule

bind vec_mac_unit vec_mac_unit_chk #(.SLICES(SLICES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .load_acc  (load_acc),
    .opa_vec   (opa_vec),
    .out_valid (out_valid),
    .acc_vec   (acc_vec)
);

// File: tb/vec_mac_unit_tb_top.sv
`timescale 1ns/1ps
module vec_mac_unit_tb_top;

    localparam int SLICES = 4;
    localparam int A_W    = 128 * SLICES;
    localparam int B_W    = 64 * SLICES;
    localparam int ACC_W  = 32 * SLICES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [A_W-1:0]   opa_vec = '0;
    logic [B_W-1:0]   opb_vec = '0;
    logic [2:0]       prec_mode = '0;
    logic             opa_signed = 1'b0;
    logic             opb_signed = 1'b0;
    logic             load_acc = 1'b0;
    logic             out_valid;
    logic [ACC_W-1:0] acc_vec;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    bit    cmp_on   = 1'b0;
    string cur_req  = "R1";

    always #2.5 clk = ~clk;

    vec_mac_unit #(.SLICES(SLICES)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .opa_vec    (opa_vec),
        .opb_vec    (opb_vec),
        .prec_mode  (prec_mode),
        .opa_signed (opa_signed),
        .opb_signed (opb_signed),
        .load_acc   (load_acc),
        .out_valid  (out_valid),
        .acc_vec    (acc_vec)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [ACC_W-1:0] got, input logic [ACC_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic longint elem(input logic [A_W-1:0] v, input int pos,
                                    input int w, input logic sgn);
        longint r = 0;
        for (int i = 0; i < w; i++) begin
            if (v[pos+i]) r = r | (longint'(1) << i);
        end
        if (sgn && v[pos+w-1]) r = r - (longint'(1) << w);
        return r;
    endfunction

    function automatic logic [ACC_W-1:0] model_step(
        input logic [ACC_W-1:0] acc, input logic [2:0] m,
        input logic [A_W-1:0] a, input logic [B_W-1:0] b,
        input logic sa, input logic sb, input logic ld);
        logic [ACC_W-1:0] res = acc;
        int wa = 8, wb = 8, per = 8, lw = 32;
        case (m)
            3'd1: begin wa = 8;  wb = 4;  per = 16; lw = 32; end
            3'd2: begin wa = 16; wb = 16; per = 2;  lw = 32; end
            3'd3: begin wa = 16; wb = 16; per = 4;  lw = 64; end
            3'd4: begin wa = 16; wb = 8;  per = 4;  lw = 32; end
            3'd5: begin wa = 16; wb = 8;  per = 8;  lw = 64; end
            default: ;
        endcase
        for (int l = 0; l < ACC_W / lw; l++) begin
            longint s = 0;
            longint old = 0;
            for (int k = 0; k < per; k++) begin
                int idx = l * per + k;
                s = s + elem(a, idx * wa, wa, sa) * elem(A_W'(b), idx * wb, wb, sb);
            end
            for (int i = 0; i < lw; i++) begin
                if (acc[l*lw+i]) old = old | (longint'(1) << i);
            end
            if (!ld) s = s + old;
            for (int i = 0; i < lw; i++) res[l*lw+i] = s[i];
        end
        return res;
    endfunction

    logic [ACC_W-1:0] m_acc = '0, p0_acc = '0, p1_acc = '0, e_acc = '0;
    logic             p0_v = 1'b0, p1_v = 1'b0, e_v = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; p0_acc = '0; p1_acc = '0; e_acc = '0;
            p0_v = 1'b0; p1_v = 1'b0; e_v = 1'b0;
        end else begin
            e_v = p1_v;
            if (p1_v) e_acc = p1_acc;
            p1_v = p0_v;
            p1_acc = p0_acc;
            p0_v = in_valid;
            if (in_valid) begin
                m_acc = model_step(m_acc, prec_mode, opa_vec, opb_vec,
                                   opa_signed, opb_signed, load_acc);
            end
            p0_acc = m_acc;
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(out_valid == e_v, "R2 out_valid", ACC_W'(out_valid), ACC_W'(e_v));
            chk(acc_vec == e_acc, cur_req, acc_vec, e_acc);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic issue(input logic [2:0] m, input logic [A_W-1:0] a,
                         input logic [B_W-1:0] b, input logic sa,
                         input logic sb, input logic ld);
        prec_mode  = m;
        opa_vec    = a;
        opb_vec    = b;
        opa_signed = sa;
        opb_signed = sb;
        load_acc   = ld;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_lane(input int lw, input int l, input logic [63:0] exp,
                              input string req);
        logic [63:0] got = '0;
        for (int i = 0; i < lw; i++) got[i] = acc_vec[l*lw+i];
        chk(got == exp, req, ACC_W'(got), ACC_W'(exp));
    endtask

    task automatic check_all(input int lw, input logic [63:0] exp, input string req);
        for (int l = 0; l < ACC_W / lw; l++) check_lane(lw, l, exp, req);
    endtask

    localparam logic [A_W-1:0] A_FF   = {(A_W/8){8'hFF}};
    localparam logic [B_W-1:0] B_FF   = {(B_W/8){8'hFF}};
    localparam logic [A_W-1:0] A_ONE16 = {(A_W/16){16'h0001}};
    localparam logic [B_W-1:0] B_ONE8 = {(B_W/8){8'h01}};

    initial begin
        logic [A_W-1:0] ta;
        logic [B_W-1:0] tb;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && acc_vec == '0, "R1 in reset", acc_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && acc_vec == '0, "R1 after release", acc_vec, '0);
        cmp_on = 1'b1;

        // R6: signedness combinations, int8 x int8 load
        cur_req = "R6";
        issue(3'd0, A_FF, B_FF, 1'b1, 1'b1, 1'b1); settle();
        check_all(32, 64'd8, "R6 signed*signed");
        issue(3'd0, A_FF, B_FF, 1'b0, 1'b0, 1'b1); settle();
        check_all(32, 64'h0007_F008, "R6 unsigned*unsigned");
        issue(3'd0, A_FF, B_FF, 1'b1, 1'b0, 1'b1); settle();
        check_all(32, 64'hFFFF_F808, "R6 signed*unsigned");

        // R7 then R8: load, then wrapping accumulate in 32-bit lanes
        cur_req = "R8";
        issue(3'd2, A_FF, B_FF, 1'b0, 1'b0, 1'b1); settle();
        check_all(32, 64'hFFFC_0002, "R7 load u16*u16");
        issue(3'd2, A_FF, B_FF, 1'b0, 1'b0, 1'b0); settle();
        check_all(32, 64'hFFF8_0004, "R8 wrap accumulate");

        // R4: wide lanes, 4 products per 64-bit lane
        cur_req = "R4";
        issue(3'd3, A_FF, B_FF, 1'b0, 1'b0, 1'b1); settle();
        check_all(64, 64'h3_FFF8_0004, "R4 wide u16*u16");

        // R9: narrow load then wide accumulate over the same register
        cur_req = "R9";
        issue(3'd0, A_FF, B_FF, 1'b1, 1'b1, 1'b1);
        issue(3'd5, A_ONE16, B_ONE8, 1'b1, 1'b1, 1'b0); settle();
        check_all(64, 64'h0000_0008_0000_0010, "R9 shared lanes");

        // R5: element placement and lane grouping
        cur_req = "R5";
        ta = '0; tb = '0;
        ta[5*16 +: 16] = 16'd3;
        tb[5*8 +: 8]   = 8'd7;
        issue(3'd4, ta, tb, 1'b1, 1'b1, 1'b1); settle();
        check_lane(32, 0, 64'd0, "R5 lane0 mode4");
        check_lane(32, 1, 64'd21, "R5 lane1 mode4");
        check_lane(32, 2, 64'd0, "R5 lane2 mode4");
        ta = '0; tb = '0;
        ta[17*8 +: 8] = 8'd2;
        tb[17*4 +: 4] = 4'hD;
        issue(3'd1, ta, tb, 1'b1, 1'b1, 1'b1); settle();
        check_lane(32, 1, 64'hFFFF_FFFA, "R5 lane1 mode1");
        check_lane(32, 0, 64'd0, "R5 lane0 mode1");

        // R10: unused codes behave as code 0
        cur_req = "R10";
        issue(3'd7, A_FF, B_FF, 1'b1, 1'b1, 1'b1); settle();
        check_all(32, 64'd8, "R10 code7");
        issue(3'd6, A_FF, B_FF, 1'b0, 1'b0, 1'b0); settle();
        check_all(32, 64'h0007_F010, "R10 code6");

        // R3: inputs with in_valid low have no effect
        cur_req = "R3";
        prec_mode = 3'd2; opa_vec = A_FF; opb_vec = B_FF; load_acc = 1'b1;
        repeat (5) @(negedge clk);
        check_all(32, 64'h0007_F010, "R3 hold");
        chk(!out_valid, "R3 out_valid low", ACC_W'(out_valid), '0);

        // R2/R4: random back-to-back traffic against the reference
        cur_req = "R4 random";
        for (int c = 0; c < 400; c++) begin
            for (int i = 0; i < A_W / 32; i++) opa_vec[i*32 +: 32] = $urandom();
            for (int i = 0; i < B_W / 32; i++) opb_vec[i*32 +: 32] = $urandom();
            prec_mode  = 3'($urandom % 8);
            opa_signed = 1'($urandom % 2);
            opb_signed = 1'($urandom % 2);
            load_acc   = (($urandom % 4) == 0);
            in_valid   = (($urandom % 10) < 7);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog got %0d cycles expected fewer", 20000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule